// File: doc/BRIEF.md
# Linked-List Receive DMA Channel

This block moves an incoming endpoint byte stream into memory buffers that software describes with a circular chain of four-word descriptors. For each descriptor it reads the link, the buffer address and the buffer size, fills that buffer one byte at a time, and then writes back the descriptor's status word. The status word holds the byte count and the start-of-frame, end-of-frame, end-of-queue and zero-length flags, and it always has the ownership bit cleared. A frame is a run of endpoint packets that ends on a short packet or on an empty packet. When a frame is longer than one buffer it spills into the following descriptors.

Software gives the engine buffers by adding to a credit counter. The engine consumes one credit for each buffer it closes. With no credit left it holds the stream off and fetches no descriptor. When it closes a descriptor whose link word is zero, it marks end of queue and stops; software starts it again through the head pointer register. Software acknowledges finished descriptors by writing their address to a completion register. The interrupt stays raised while the most recently closed descriptor has not been acknowledged.

Top module: `rxdesc_dma`

## Requirements
- R1: A descriptor is four 32-bit words at byte offsets 0 (link to the next descriptor, 0 means none), 4 (buffer byte address), 8 (buffer size in bits 15:0) and 12 (status). The engine reads the first three words and writes only the status word. Memory returns read data in the cycle after the one in which mem_req is high with mem_we low.
- R2: The status word written back has start-of-frame at bit 31, end-of-frame at bit 30, ownership at bit 29 (always 0), end-of-queue at bit 28, the zero-length flag at bit 23, the byte count in bits 15:0 and all other bits 0.
- R3: The register at reg_addr 1 holds the free-buffer credit. It is 0 after reset. A write adds reg_wdata to it modulo 2^CW, so a two's-complement negative value drains it. reg_rdata returns the register selected by reg_addr one cycle later (0 head, 1 credit, 2 completion).
- R4: The credit drops by exactly one for each descriptor the engine closes.
- R5: While the credit is zero, the engine issues no memory read and keeps s_ready low.
- R6: Byte k of a buffer is written at buffer address + k. It uses a single byte lane, selected by bits 1:0 of that address, with the byte repeated on all four lanes of mem_wdata.
- R7: A packet is the bytes up to and including one with s_last. A packet shorter than MPS bytes ends the frame. A packet of exactly MPS bytes does not end the frame.
- R8: A buffer is closed when it reaches its size or when the frame ends. Only the buffer in which the frame ends has end-of-frame set, and only the first buffer of a frame has start-of-frame set.
- R9: An empty packet (s_valid with s_zlp) ends the frame. If the current buffer is empty, the buffer is closed with count 0, end-of-frame and the zero-length flag. Otherwise it is closed with its byte count and end-of-frame, and without the zero-length flag.
- R10: When the engine closes a descriptor whose link is 0, it sets end-of-queue in that status word, stops, and keeps s_ready low. Reading the head register returns the current descriptor address.
- R11: A head register write while the engine is stopped restarts it at the written address. A head write while the engine is running has no effect.
- R12: irq is high when at least one descriptor has been closed and the address of the latest one differs from the completion register. Writing that address to the completion register drops irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 head, 1 credit, 2 completion |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register, one cycle after reg_addr |
| irq | output | 1 | Unacknowledged closed descriptor |
| s_valid | input | 1 | Stream item valid |
| s_ready | output | 1 | Engine accepts a stream item |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Byte is the last of its packet |
| s_zlp | input | 1 | Item is an empty packet and carries no byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |

## Verification
The bench targets the points where a frame's flags are easy to get wrong. These are a full-size packet that straddles a buffer edge, a frame that ends exactly on a full buffer, and an empty packet that arrives both with an open buffer and after a buffer has just filled. A design that compared packet length against the buffer size instead of MPS, or that copied start-of-frame onto every buffer, would show wrong bits 31/30 in those status words. One that always set the zero-length flag on an empty packet would mark a buffer that still holds data. The bench also checks several stalls: that a zero credit truly stalls fetch, that a head write while running cannot redirect the chain, and that a null link stops the engine with end-of-queue. A design that ignored these would fetch from garbage, write into the wrong descriptor, or keep taking bytes after the queue ended.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;
  // status word bit positions
  localparam int ST_SOF_BIT = 31;
  localparam int ST_EOF_BIT = 30;
  localparam int ST_OWN_BIT = 29;
  localparam int ST_EOQ_BIT = 28;
  localparam int ST_ZLP_BIT = 23;

  // word index inside a descriptor
  localparam int DW_LINK = 0;
  localparam int DW_BUF  = 1;
  localparam int DW_SIZE = 2;
  localparam int DW_STAT = 3;

  // register select
  localparam logic [1:0] RA_HEAD = 2'd0;
  localparam logic [1:0] RA_FREE = 2'd1;
  localparam logic [1:0] RA_CMPL = 2'd2;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_GATE,
    ENG_FETCH,
    ENG_FILL,
    ENG_CLOSE
  } eng_state_e;

  function automatic logic [31:0] pack_status(input logic sof, input logic eof,
                                              input logic eoq, input logic zlp,
                                              input logic [15:0] cnt);
    logic [31:0] w;
    w = '0;
    w[ST_SOF_BIT] = sof;
    w[ST_EOF_BIT] = eof;
    w[ST_OWN_BIT] = 1'b0;
    w[ST_EOQ_BIT] = eoq;
    w[ST_ZLP_BIT] = zlp;
    w[15:0] = cnt;
    return w;
  endfunction
endpackage

// File: rtl/rxdesc_regs.sv
module rxdesc_regs
  import rxdesc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  input  logic          busy,
  input  logic [AW-1:0] cur_ptr,
  input  logic          buf_done,
  input  logic [AW-1:0] done_addr,
  output logic [CW-1:0] free_cnt,
  output logic          start,
  output logic [AW-1:0] start_ptr
);
  logic [AW-1:0] cmpl_q;
  logic [AW-1:0] last_done_q;
  logic          any_done_q;
  logic [CW-1:0] add_v;
  logic [CW-1:0] free_nx;
  logic          wr_head, wr_free, wr_cmpl;

  assign wr_head = reg_wr && (reg_addr == RA_HEAD);
  assign wr_free = reg_wr && (reg_addr == RA_FREE);
  assign wr_cmpl = reg_wr && (reg_addr == RA_CMPL);

  always_comb begin
    add_v   = wr_free ? reg_wdata[CW-1:0] : '0;
    free_nx = free_cnt + add_v - {{(CW-1){1'b0}}, buf_done};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_cnt    <= '0;
      start       <= 1'b0;
      start_ptr   <= '0;
      cmpl_q      <= '0;
      last_done_q <= '0;
      any_done_q  <= 1'b0;
      irq         <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      free_cnt <= free_nx;
      start    <= wr_head && !busy && !start;
      if (wr_head && !busy && !start) start_ptr <= reg_wdata[AW-1:0];
      if (wr_cmpl) cmpl_q <= reg_wdata[AW-1:0];
      if (buf_done) begin
        last_done_q <= done_addr;
        any_done_q  <= 1'b1;
      end
      irq <= any_done_q && (last_done_q != cmpl_q);
      case (reg_addr)
        RA_HEAD: reg_rdata <= 32'(cur_ptr);
        RA_FREE: reg_rdata <= 32'(free_cnt);
        RA_CMPL: reg_rdata <= 32'(cmpl_q);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rxdesc_framer.sv
module rxdesc_framer #(
  parameter int MPS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic take_byte,
  input  logic take_zlp,
  input  logic byte_last,
  input  logic wb_fire,
  input  logic wb_eof,
  output logic short_end,
  output logic sof_pend
);
  localparam int PW = $clog2(MPS + 1);
  localparam logic [PW-1:0] MPS_V = PW'(MPS);

  logic [PW-1:0] pkt_len;

  // the byte being taken closes a packet shorter than the maximum size
  assign short_end = take_byte && byte_last && ((pkt_len + 1'b1) < MPS_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_len  <= '0;
      sof_pend <= 1'b1;
    end else begin
      if (take_zlp) begin
        pkt_len <= '0;
      end else if (take_byte) begin
        if (byte_last)             pkt_len <= '0;
        else if (pkt_len != MPS_V) pkt_len <= pkt_len + 1'b1;
      end
      if (wb_fire) sof_pend <= wb_eof;
    end
  end
endmodule

// File: rtl/rxdesc_ctrl.sv
module rxdesc_ctrl
  import rxdesc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  input  logic          free_nz,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_zlp,
  output logic          s_ready,
  input  logic          short_end,
  input  logic          sof_pend,
  output logic          take_byte,
  output logic          take_zlp,
  output logic          buf_done,
  output logic          wb_eof,
  output logic [AW-1:0] done_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic [AW-1:0] cur_ptr
);
  localparam logic [AW-1:0] OFS_STAT = AW'(4 * DW_STAT);

  eng_state_e    state_q;
  logic [2:0]    fcnt_q;
  logic [AW-1:0] cur_q, link_q, bptr_q;
  logic [15:0]   bsize_q, off_q, off_nx;
  logic          eof_q, zf_q;
  logic [AW-1:0] baddr;

  assign take_byte = s_ready && s_valid && !s_zlp;
  assign take_zlp  = s_ready && s_valid && s_zlp;
  assign buf_done  = (state_q == ENG_CLOSE);
  assign wb_eof    = eof_q;
  assign done_addr = cur_q;
  assign busy      = (state_q != ENG_IDLE);
  assign cur_ptr   = cur_q;
  assign off_nx    = off_q + 16'd1;
  assign baddr     = bptr_q + AW'(off_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ENG_IDLE;
      fcnt_q    <= '0;
      cur_q     <= '0;
      link_q    <= '0;
      bptr_q    <= '0;
      bsize_q   <= '0;
      off_q     <= '0;
      eof_q     <= 1'b0;
      zf_q      <= 1'b0;
      s_ready   <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      case (state_q)
        ENG_IDLE: begin
          if (start) begin
            cur_q   <= start_ptr;
            state_q <= ENG_GATE;
          end
        end
        ENG_GATE: begin
          if (free_nz) begin
            fcnt_q  <= '0;
            state_q <= ENG_FETCH;
          end
        end
        ENG_FETCH: begin
          // reads issued at counts 0..2, data captured two counts later
          if (fcnt_q < 3'd3) begin
            mem_req  <= 1'b1;
            mem_addr <= cur_q + AW'({fcnt_q, 2'b00});
            mem_be   <= 4'hF;
          end
          case (fcnt_q)
            3'd2: link_q <= mem_rdata[AW-1:0];
            3'd3: bptr_q <= mem_rdata[AW-1:0];
            3'd4: begin
              bsize_q <= mem_rdata[15:0];
              off_q   <= '0;
              s_ready <= 1'b1;
              state_q <= ENG_FILL;
            end
            default: ;
          endcase
          fcnt_q <= fcnt_q + 3'd1;
        end
        ENG_FILL: begin
          if (take_zlp) begin
            eof_q   <= 1'b1;
            zf_q    <= (off_q == 16'd0);
            s_ready <= 1'b0;
            state_q <= ENG_CLOSE;
          end else if (take_byte) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= baddr;
            mem_be    <= 4'b0001 << baddr[1:0];
            mem_wdata <= {4{s_data}};
            off_q     <= off_nx;
            if (short_end || (off_nx >= bsize_q)) begin
              eof_q   <= short_end;
              zf_q    <= 1'b0;
              s_ready <= 1'b0;
              state_q <= ENG_CLOSE;
            end
          end
        end
        ENG_CLOSE: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= cur_q + OFS_STAT;
          mem_be    <= 4'hF;
          mem_wdata <= pack_status(sof_pend, eof_q, (link_q == '0), zf_q, off_q);
          if (link_q == '0) begin
            state_q <= ENG_IDLE;
          end else begin
            cur_q   <= link_q;
            state_q <= ENG_GATE;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma
  import rxdesc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int MPS = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic          s_zlp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  logic          busy_w, start_w, buf_done_w, wb_eof_w;
  logic          take_byte_w, take_zlp_w, short_end_w, sof_pend_w;
  logic [AW-1:0] cur_w, start_ptr_w, done_addr_w;
  logic [CW-1:0] free_cnt_w;

  rxdesc_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .busy(busy_w), .cur_ptr(cur_w), .buf_done(buf_done_w),
    .done_addr(done_addr_w), .free_cnt(free_cnt_w), .start(start_w),
    .start_ptr(start_ptr_w)
  );

  rxdesc_framer #(.MPS(MPS)) u_framer (
    .clk(clk), .rst(rst), .take_byte(take_byte_w), .take_zlp(take_zlp_w),
    .byte_last(s_last), .wb_fire(buf_done_w), .wb_eof(wb_eof_w),
    .short_end(short_end_w), .sof_pend(sof_pend_w)
  );

  rxdesc_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_w), .start_ptr(start_ptr_w),
    .free_nz(free_cnt_w != '0), .s_valid(s_valid), .s_data(s_data),
    .s_zlp(s_zlp), .s_ready(s_ready), .short_end(short_end_w),
    .sof_pend(sof_pend_w), .take_byte(take_byte_w), .take_zlp(take_zlp_w),
    .buf_done(buf_done_w), .wb_eof(wb_eof_w), .done_addr(done_addr_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy_w), .cur_ptr(cur_w)
  );
endmodule

// File: rtl/rxdesc_chk.sv
module rxdesc_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_wdata,
  input logic          s_ready,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic          buf_done,
  input logic [CW-1:0] free_cnt
);
  logic stat_wr;
  assign stat_wr = mem_req && mem_we && (mem_be == 4'hF);

  // R2: status write-back always hands the buffer back to software
  p_own_clear_r2: assert property (@(posedge clk) disable iff (rst)
    stat_wr |-> !mem_wdata[29]);

  // R9: zero-length flag only with count 0 and end-of-frame
  p_zlp_mark_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && mem_wdata[23]) |-> (mem_wdata[15:0] == 16'd0 && mem_wdata[30]));

  // R6: buffer bytes use exactly one lane
  p_one_lane_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

  // R4: closing a buffer takes exactly one credit
  p_credit_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (buf_done && !(reg_wr && reg_addr == 2'd1)) |=> (free_cnt == $past(free_cnt) - 1'b1));

  // R10: end of queue leaves the stream held off
  p_eoq_stop_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && mem_wdata[28]) |=> !s_ready);
endmodule

bind rxdesc_dma rxdesc_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
  .mem_wdata(mem_wdata), .s_ready(s_ready), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .buf_done(buf_done_w), .free_cnt(free_cnt_w)
);

// File: tb/sim_rxdesc_dma.sv
`timescale 1ns/1ps
module sim_rxdesc_dma;
  localparam int AW = 16;
  localparam int MPS = 8;
  localparam int BSZ = 12;
  localparam int NPK = 20;
  localparam int PKT_LEN [NPK] = '{3, 8, 8, 2, 8, 0, 0, 8, 8, 8, 5, 7, 8, 4, 6, 6, 8, 8, 8, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, s_ready;
  logic s_valid = 1'b0, s_last = 1'b0, s_zlp = 1'b0;
  logic [7:0] s_data = '0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [0:255];
  logic tb_we = 1'b0;
  logic [7:0] tb_idx = '0;
  logic [31:0] tb_dat = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  int m_idx, m_off, m_sof, m_stop, m_seq, m_wbs;
  int e_addr [0:15];
  int e_byte [0:15];
  int n_e;
  int w_idx [0:3];
  logic [31:0] w_stat [0:3];
  int n_w;

  always #2.5 clk = ~clk;

  rxdesc_dma #(.AW(AW), .CW(16), .MPS(MPS)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_zlp(s_zlp), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] rd_q = '0;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (tb_we) begin
      mem[tb_idx] <= tb_dat;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr[9:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
      end else begin
        rd_q <= mem[mem_addr[9:2]];
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000 && !finished) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog (all R): got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] st_word(input int sof, input int eof, input int eoq,
                                          input int z, input int cnt);
    return {sof[0], eof[0], 1'b0, eoq[0], 4'b0, z[0], 7'b0, cnt[15:0]};
  endfunction

  function automatic int daddr(input int i);
    return 32'h100 + 16 * i;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mem_set(input int word, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_idx = word[7:0]; tb_dat = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic send_item(input logic zlp, input logic [7:0] d, input logic last);
    s_valid = 1'b1; s_zlp = zlp; s_data = d; s_last = last;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1;
    s_valid = 1'b0; s_zlp = 1'b0; s_last = 1'b0;
  endtask

  task automatic model_close(input int eof, input int z);
    w_idx[n_w]  = m_idx;
    w_stat[n_w] = st_word(m_sof, eof, (m_idx == m_stop) ? 1 : 0, z, m_off);
    n_w = n_w + 1;
    m_wbs = m_wbs + 1;
    m_sof = eof;
    m_idx = (m_idx + 1) % 4;
    m_off = 0;
  endtask

  // sends one packet (0 = empty packet) and checks bytes and status words
  task automatic run_packet(input int len);
    n_e = 0; n_w = 0;
    if (len == 0) begin
      send_item(1'b1, 8'h00, 1'b0);
      model_close(1, (m_off == 0) ? 1 : 0);
    end else begin
      for (int j = 0; j < len; j++) begin
        logic [7:0] b;
        b = m_seq[7:0];
        m_seq = m_seq + 1;
        send_item(1'b0, b, (j == len - 1));
        e_addr[n_e] = 32'h200 + 16 * m_idx + m_off;
        e_byte[n_e] = b;
        n_e = n_e + 1;
        m_off = m_off + 1;
        if (m_off == BSZ || (j == len - 1 && len < MPS))
          model_close((j == len - 1 && len < MPS) ? 1 : 0, 0);
      end
    end
    repeat (12) @(negedge clk);
    for (int k = 0; k < n_e; k++)
      check("R6 R11 byte placement", 32'(mem[e_addr[k] / 4][8 * (e_addr[k] % 4) +: 8]), e_byte[k]);
    for (int k = 0; k < n_w; k++)
      check("R2 R7 R8 R9 R10 status", mem[daddr(w_idx[k]) / 4 + 3], w_stat[k]);
  endtask

  initial begin
    logic [31:0] rv;
    int stop_i, k;
    m_idx = 0; m_off = 0; m_sof = 1; m_stop = -1; m_seq = 8'h31; m_wbs = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R3 reset irq", 32'(irq), 0);
    check("R5 reset s_ready", 32'(s_ready), 0);
    check("R1 reset mem_req", 32'(mem_req), 0);
    reg_read(2'd1, rv); check("R3 reset credit", rv, 0);
    reg_read(2'd2, rv); check("R12 reset completion", rv, 0);

    // ring of four descriptors
    for (int i = 0; i < 4; i++) begin
      mem_set(daddr(i) / 4 + 0, daddr((i + 1) % 4));
      mem_set(daddr(i) / 4 + 1, 32'h200 + 16 * i);
      mem_set(daddr(i) / 4 + 2, BSZ);
      mem_set(daddr(i) / 4 + 3, 32'h2000_0000);
    end

    // credit arithmetic, including drains
    reg_write(2'd1, 32'd5);
    reg_write(2'd1, 32'hFFFF_FFFD);
    reg_read(2'd1, rv); check("R3 credit add/drain", rv, 2);
    reg_write(2'd1, 32'hFFFF_FFFE);
    reg_read(2'd1, rv); check("R3 credit drained", rv, 0);

    // zero credit: started but no fetch, stream held off
    reg_write(2'd0, daddr(0));
    begin
      bit saw;
      saw = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (mem_req || s_ready) saw = 1;
      end
      check("R5 stall with zero credit", 32'(saw), 0);
    end
    reg_read(2'd0, rv); check("R10 head readback", rv, daddr(0));

    reg_write(2'd1, 32'd40);
    for (int v = 0; v < NPK; v++) run_packet(PKT_LEN[v]);

    reg_read(2'd1, rv); check("R4 credit per buffer", rv, 40 - m_wbs);

    // interrupt and acknowledge
    check("R12 irq pending", 32'(irq), 1);
    reg_write(2'd2, 32'h1F0);
    repeat (2) @(negedge clk);
    check("R12 irq after wrong ack", 32'(irq), 1);
    reg_write(2'd2, daddr((m_idx + 3) % 4));
    repeat (2) @(negedge clk);
    check("R12 irq cleared", 32'(irq), 0);

    // head write while running is ignored
    reg_write(2'd0, 32'h300);
    reg_read(2'd0, rv); check("R11 head ignored while running", rv, daddr(m_idx));
    run_packet(3);

    // null link stops the engine with end of queue
    stop_i = (m_idx + 1) % 4;
    mem_set(daddr(stop_i) / 4, 32'h0);
    m_stop = stop_i;
    run_packet(3);
    run_packet(2);
    repeat (5) @(negedge clk);
    check("R10 stopped s_ready", 32'(s_ready), 0);
    reg_read(2'd0, rv); check("R10 head at stop", rv, daddr(stop_i));

    // restart at a chosen descriptor
    k = (stop_i + 2) % 4;
    m_stop = -1;
    reg_write(2'd0, daddr(k));
    m_idx = k;
    run_packet(5);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule